// File: doc/BRIEF.md
# LIN Response Byte Engine

This block handles the byte-level part of a LIN frame once the break and sync field are over. It takes the identifier byte first, then the response data bytes, and in the right cases the checksum byte. In the master role it adds the two identifier parity bits to the identifier and appends the checksum after the last data byte. In the slave role it checks the parity of the received protected identifier and the received checksum. The block raises a sticky error flag when either check fails.

Bytes enter on a valid/ready input stream and leave on a valid/ready output stream. A one-cycle `frame_start` pulse starts every frame. The pulse also captures the mode inputs: node role, parity disable, checksum disable, checksum type, length source and length code. Those inputs can therefore change while a frame is running without affecting that frame. Bit timing, break and sync generation, baud tracking and wakeup signalling belong to neighbouring blocks.

Top module: `lin_resp_engine`

## Requirements
- R1: In the master role with parity enabled, the identifier byte leaves with its low six bits unchanged. Bit 6 is set to id0^id1^id2^id4 and bit 7 is set to the inverse of id1^id3^id4^id5.
- R2: With parity disabled, the identifier byte passes through unchanged in both roles, and a bad parity never sets `par_err`.
- R3: In the slave role with parity enabled, the received identifier is forwarded as it arrived. If its bits 7:6 differ from the parity of its bits 5:0, `par_err` is set and stays set until the next `frame_start`.
- R4: When the length source input is 0, the response holds length-code+1 data bytes, for codes 0 to 255.
- R5: When the length source input is 1, identifier bits 5:4 set the data length and the length code is ignored. The values 00 and 01 give 2 bytes, 10 gives 4 bytes and 11 gives 8 bytes.
- R6: The checksum is the bitwise inverse of an 8-bit sum in which each carry out of bit 7 is added back into bit 0. With checksum type 1 (classic), only the data bytes are summed.
- R7: With checksum type 0 (enhanced), the sum also includes the protected identifier, as sent or received.
- R8: In the master role with the checksum enabled, exactly one checksum byte is emitted right after the last data byte. That byte is held on the output until it is accepted.
- R9: In the slave role with the checksum enabled, the byte after the last data byte is consumed and not forwarded. If it differs from the expected checksum, `sum_err` is set and stays set until the next `frame_start`.
- R10: With the checksum disabled, no checksum is emitted, consumed or checked in either role, and the frame ends after the last data byte.
- R11: `frame_start` clears both error flags and restarts the frame even in the middle of a frame. The mode inputs are captured only on `frame_start`.
- R12: `frame_done` is high for exactly one cycle, in the cycle after the final byte of a frame is transferred.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | One-cycle pulse that begins a frame and captures the modes |
| cfg_master | input | 1 | 1 = master role, 0 = slave role |
| cfg_par_off | input | 1 | 1 = no identifier parity handling |
| cfg_sum_off | input | 1 | 1 = no checksum handling |
| cfg_classic | input | 1 | 1 = classic checksum, 0 = enhanced |
| cfg_len_from_id | input | 1 | 1 = length from identifier bits 5:4 |
| cfg_len_code | input | CODE_W | Data length minus one when the length comes from the code |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Input byte accepted |
| in_data | input | 8 | Input byte |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream accepts the output byte |
| out_data | output | 8 | Output byte |
| par_err | output | 1 | Sticky identifier parity error |
| sum_err | output | 1 | Sticky checksum error |
| frame_done | output | 1 | One-cycle end-of-frame pulse |

## Verification
The bench covers the length boundaries: code 0, which gives one byte, and code 255, which gives 256 bytes. A counter one bit too narrow, or an off-by-one on the last index, would end the frame early or late and leave stray or missing bytes in the scoreboard. It runs all four identifier length codes with a distracting length code applied. A design that mixed up the two sources, or mapped 00 and 01 differently, would produce the wrong byte count. Both checksum types are run with random data so that carries occur often. A design that dropped the end-around carry, or left the identifier out of the enhanced sum, would produce a wrong checksum byte in the master role and a false `sum_err` in the slave role. The bench also changes the mode inputs in the middle of a frame, restarts a frame partway through, and sends corrupted parity and checksum bytes with each disable switch set. A design that read the live mode inputs, or that checked something it had been told to skip, would show up in the scoreboard or in the error flags.

// File: rtl/lin_resp_pkg.sv
package lin_resp_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ID   = 2'd1,
    ST_DATA = 2'd2,
    ST_SUM  = 2'd3
  } lin_st_e;

  // Protected-identifier parity pair {p1, p0} for a 6-bit identifier
  function automatic logic [1:0] id_parity(input logic [5:0] id);
    return {~(id[1] ^ id[3] ^ id[4] ^ id[5]), (id[0] ^ id[1] ^ id[2] ^ id[4])};
  endfunction

  // 8-bit addition with the carry folded back into bit 0
  function automatic logic [7:0] sum_wrap(input logic [7:0] a, input logic [7:0] b);
    logic [8:0] t;
    t = {1'b0, a} + {1'b0, b};
    return t[7:0] + {7'b0, t[8]};
  endfunction

endpackage

// File: rtl/lin_rst_sync.sv
module lin_rst_sync (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= 2'b00;
    else          sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/lin_pid_unit.sv
module lin_pid_unit (
  input  logic [7:0] id_in,
  input  logic       gen_en,
  output logic [7:0] pid_out,
  output logic       par_ok
);
  import lin_resp_pkg::*;

  logic [1:0] par;

  always_comb begin
    par     = id_parity(id_in[5:0]);
    pid_out = gen_en ? {par, id_in[5:0]} : id_in;
    par_ok  = (id_in[7:6] == par);
  end
endmodule

// File: rtl/lin_len_decode.sv
module lin_len_decode #(
  parameter int CODE_W = 8,
  localparam int CNT_W = CODE_W + 1
) (
  input  logic              from_id,
  input  logic [CODE_W-1:0] code,
  input  logic [1:0]        id_len_bits,
  output logic [CNT_W-1:0]  last_idx
);
  always_comb begin
    if (from_id) begin
      case (id_len_bits)
        2'b10:   last_idx = CNT_W'(3);
        2'b11:   last_idx = CNT_W'(7);
        default: last_idx = CNT_W'(1);
      endcase
    end else begin
      last_idx = {1'b0, code};
    end
  end
endmodule

// File: rtl/lin_sum_acc.sv
module lin_sum_acc #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         init_en,
  input  logic [W-1:0] init_val,
  input  logic         add_en,
  input  logic [W-1:0] add_val,
  output logic [W-1:0] sum_q
);
  logic [W-1:0] sum_d;
  logic [W:0]   raw;

  always_comb begin
    raw   = {1'b0, sum_q} + {1'b0, add_val};
    sum_d = sum_q;
    if (init_en)     sum_d = init_val;
    else if (add_en) sum_d = raw[W-1:0] + {{(W-1){1'b0}}, raw[W]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sum_q <= '0;
    else        sum_q <= sum_d;
  end
endmodule

// File: rtl/lin_resp_engine.sv
module lin_resp_engine #(
  parameter int CODE_W = 8,
  localparam int CNT_W = CODE_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              cfg_master,
  input  logic              cfg_par_off,
  input  logic              cfg_sum_off,
  input  logic              cfg_classic,
  input  logic              cfg_len_from_id,
  input  logic [CODE_W-1:0] cfg_len_code,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [7:0]        out_data,
  output logic              par_err,
  output logic              sum_err,
  output logic              frame_done
);
  import lin_resp_pkg::*;

  logic rst_sn;
  lin_st_e st_q, st_d;
  logic master_q, par_off_q, sum_off_q, classic_q, from_id_q;
  logic [CODE_W-1:0] code_q;
  logic [CNT_W-1:0] cnt_q, cnt_d, last_q, last_d, last_dec;
  logic par_err_q, par_err_d, sum_err_q, sum_err_d, done_q, done_d;
  logic [7:0] pid_out, sum_q;
  logic par_ok, fire_in, init_en, add_en;

  lin_rst_sync u_rst (.clk(clk), .rst_n_i(rst_n), .rst_n_o(rst_sn));

  lin_pid_unit u_pid (
    .id_in(in_data), .gen_en(master_q & ~par_off_q),
    .pid_out(pid_out), .par_ok(par_ok)
  );

  lin_len_decode #(.CODE_W(CODE_W)) u_len (
    .from_id(from_id_q), .code(code_q),
    .id_len_bits(in_data[5:4]), .last_idx(last_dec)
  );

  assign fire_in = in_valid & in_ready;
  assign init_en = (st_q == ST_ID) & fire_in & ~frame_start;
  assign add_en  = (st_q == ST_DATA) & fire_in & ~frame_start;

  lin_sum_acc #(.W(8)) u_sum (
    .clk(clk), .rst_n(rst_sn),
    .init_en(init_en), .init_val(classic_q ? 8'h00 : pid_out),
    .add_en(add_en), .add_val(in_data), .sum_q(sum_q)
  );

  // Stream steering
  always_comb begin
    in_ready  = 1'b0;
    out_valid = 1'b0;
    out_data  = in_data;
    case (st_q)
      ST_ID: begin
        in_ready  = out_ready;
        out_valid = in_valid;
        out_data  = pid_out;
      end
      ST_DATA: begin
        in_ready  = out_ready;
        out_valid = in_valid;
      end
      ST_SUM: begin
        if (master_q) begin
          out_valid = 1'b1;
          out_data  = ~sum_q;
        end else begin
          in_ready  = 1'b1;
        end
      end
      default: ;
    endcase
  end

  // Next state
  always_comb begin
    st_d      = st_q;
    cnt_d     = cnt_q;
    last_d    = last_q;
    par_err_d = par_err_q;
    sum_err_d = sum_err_q;
    done_d    = 1'b0;
    if (frame_start) begin
      st_d      = ST_ID;
      par_err_d = 1'b0;
      sum_err_d = 1'b0;
    end else begin
      case (st_q)
        ST_ID: if (fire_in) begin
          st_d   = ST_DATA;
          cnt_d  = '0;
          last_d = last_dec;
          if (!master_q && !par_off_q && !par_ok) par_err_d = 1'b1;
        end
        ST_DATA: if (fire_in) begin
          cnt_d = cnt_q + CNT_W'(1);
          if (cnt_q == last_q) begin
            st_d   = sum_off_q ? ST_IDLE : ST_SUM;
            done_d = sum_off_q;
          end
        end
        ST_SUM: begin
          if (master_q) begin
            if (out_ready) begin
              st_d   = ST_IDLE;
              done_d = 1'b1;
            end
          end else if (in_valid) begin
            if (in_data != ~sum_q) sum_err_d = 1'b1;
            st_d   = ST_IDLE;
            done_d = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      st_q      <= ST_IDLE;
      cnt_q     <= '0;
      last_q    <= '0;
      par_err_q <= 1'b0;
      sum_err_q <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      st_q      <= st_d;
      cnt_q     <= cnt_d;
      last_q    <= last_d;
      par_err_q <= par_err_d;
      sum_err_q <= sum_err_d;
      done_q    <= done_d;
    end
  end

  // Mode capture, enabled by frame_start
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      master_q  <= 1'b0;
      par_off_q <= 1'b0;
      sum_off_q <= 1'b0;
      classic_q <= 1'b0;
      from_id_q <= 1'b0;
      code_q    <= '0;
    end else if (frame_start) begin
      master_q  <= cfg_master;
      par_off_q <= cfg_par_off;
      sum_off_q <= cfg_sum_off;
      classic_q <= cfg_classic;
      from_id_q <= cfg_len_from_id;
      code_q    <= cfg_len_code;
    end
  end

  assign par_err    = par_err_q;
  assign sum_err    = sum_err_q;
  assign frame_done = done_q;
endmodule

// File: rtl/lin_resp_engine_chk.sv
module lin_resp_engine_chk (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   frame_start,
  input logic                   out_valid,
  input logic                   out_ready,
  input logic [7:0]             out_data,
  input logic                   par_err,
  input logic                   sum_err,
  input logic                   frame_done,
  input lin_resp_pkg::lin_st_e  st,
  input logic                   master_q,
  input logic                   par_off_q,
  input logic                   sum_off_q
);
  import lin_resp_pkg::*;

  // R1: transmitted identifier carries the parity pair
  p_pid_parity_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ID && master_q && !par_off_q && out_valid && out_ready) |->
      (out_data[6] == (out_data[0] ^ out_data[1] ^ out_data[2] ^ out_data[4])) &&
      (out_data[7] == !(out_data[1] ^ out_data[3] ^ out_data[4] ^ out_data[5])));

  // R3: parity error is sticky until a frame start
  p_par_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (par_err && !frame_start) |=> par_err);

  // R9: checksum error is sticky until a frame start
  p_sum_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sum_err && !frame_start) |=> sum_err);

  // R11: frame start clears both flags
  p_err_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (!par_err && !sum_err));

  // R12: done is a single-cycle pulse
  p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);

  // R10: checksum phase never entered with checksum disabled
  p_no_sum_phase_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SUM) |-> !sum_off_q);

  // R8: master checksum byte held until accepted
  p_sum_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SUM && master_q && out_valid && !out_ready && !frame_start) |=>
      (out_valid && $stable(out_data)));
endmodule

bind lin_resp_engine lin_resp_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .par_err(par_err), .sum_err(sum_err), .frame_done(frame_done),
  .st(st_q), .master_q(master_q), .par_off_q(par_off_q), .sum_off_q(sum_off_q)
);

// File: tb/lin_resp_engine_tb.sv
module lin_resp_engine_tb;
  localparam int CODE_W = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, frame_start;
  logic cfg_master, cfg_par_off, cfg_sum_off, cfg_classic, cfg_len_from_id;
  logic [CODE_W-1:0] cfg_len_code;
  logic in_valid, in_ready, out_valid, out_ready;
  logic [7:0] in_data, out_data;
  logic par_err, sum_err, frame_done;

  lin_resp_engine #(.CODE_W(CODE_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .cfg_master(cfg_master), .cfg_par_off(cfg_par_off), .cfg_sum_off(cfg_sum_off),
    .cfg_classic(cfg_classic), .cfg_len_from_id(cfg_len_from_id), .cfg_len_code(cfg_len_code),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .par_err(par_err), .sum_err(sum_err), .frame_done(frame_done)
  );

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];
  bit mon_en = 1'b0;
  bit rdy_rand = 1'b0;

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Reference model
  function automatic logic [1:0] m_par(input logic [5:0] id);
    logic p0, p1;
    p0 = id[0] ^ id[1] ^ id[2] ^ id[4];
    p1 = !(id[1] ^ id[3] ^ id[4] ^ id[5]);
    return {p1, p0};
  endfunction

  function automatic logic [7:0] m_add(input logic [7:0] a, input logic [7:0] b);
    int s;
    s = int'(a) + int'(b);
    if (s > 255) s = s - 255;
    return 8'(s);
  endfunction

  function automatic int m_len(input bit from_id, input logic [7:0] code, input logic [1:0] bits);
    if (!from_id) return int'(code) + 1;
    case (bits)
      2'b10:   return 4;
      2'b11:   return 8;
      default: return 2;
    endcase
  endfunction

  // Scoreboard monitor
  always @(negedge clk) begin
    logic [7:0] e;
    string t;
    if (mon_en && out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R8", "unexpected output byte", int'(out_data), 0);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(out_data == e, t, "output byte", int'(out_data), int'(e));
      end
    end
  end

  // Downstream ready pattern
  initial begin
    out_ready = 1'b1;
    forever begin
      @(posedge clk);
      #1;
      out_ready = rdy_rand ? (($urandom % 4) != 0) : 1'b1;
    end
  end

  task automatic push(input logic [7:0] b, input string t);
    exp_q.push_back(b);
    tag_q.push_back(t);
  endtask

  task automatic send(input logic [7:0] b);
    in_valid = 1'b1;
    in_data  = b;
    forever begin
      @(negedge clk);
      if (in_ready) break;
    end
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  task automatic start_frame(input bit master, input bit par_off, input bit sum_off,
                             input bit classic, input bit from_id, input logic [7:0] code);
    @(posedge clk);
    #1;
    cfg_master = master; cfg_par_off = par_off; cfg_sum_off = sum_off;
    cfg_classic = classic; cfg_len_from_id = from_id; cfg_len_code = code;
    frame_start = 1'b1;
    @(posedge clk);
    #1;
    frame_start = 1'b0;
    // R11: live mode inputs must not matter after capture
    cfg_master = ~master; cfg_par_off = ~par_off; cfg_sum_off = ~sum_off;
    cfg_classic = ~classic; cfg_len_from_id = ~from_id; cfg_len_code = ~code;
  endtask

  task automatic run_frame(input bit master, input bit par_off, input bit sum_off,
                           input bit classic, input bit from_id, input logic [7:0] code,
                           input logic [7:0] raw_id, input bit bad_par, input bit bad_sum);
    logic [7:0] pid, sid, sum, b;
    int n;
    bit e_par, e_sum;
    string ltag, idtag;
    pid   = par_off ? raw_id : {m_par(raw_id[5:0]), raw_id[5:0]};
    sid   = (!master && bad_par) ? (pid ^ 8'h80) : pid;
    n     = m_len(from_id, code, sid[5:4]);
    e_par = !master && !par_off && bad_par;
    e_sum = !master && !sum_off && bad_sum;
    ltag  = from_id ? "R5" : "R4";
    idtag = par_off ? "R2" : (master ? "R1" : "R3");
    start_frame(master, par_off, sum_off, classic, from_id, code);
    push(sid, idtag);
    send(master ? raw_id : sid);
    sum = classic ? 8'h00 : sid;
    for (int i = 0; i < n; i++) begin
      b = 8'($urandom);
      push(b, ltag);
      send(b);
      sum = m_add(sum, b);
    end
    if (!sum_off) begin
      if (master) push(~sum, classic ? "R6" : "R7");
      else        send(~sum ^ (bad_sum ? 8'h01 : 8'h00));
    end
    forever begin
      @(negedge clk);
      if (frame_done) break;
    end
    chk(exp_q.size() == 0, sum_off ? "R10" : "R8", "bytes missing at frame end", exp_q.size(), 0);
    chk(par_err == e_par, par_off ? "R2" : "R3", "par_err", int'(par_err), int'(e_par));
    chk(sum_err == e_sum, sum_off ? "R10" : "R9", "sum_err", int'(sum_err), int'(e_sum));
    @(negedge clk);
    chk(!frame_done, "R12", "frame_done width", int'(frame_done), 0);
  endtask

  task automatic main_seq();
    rst_n = 1'b0; frame_start = 1'b0; in_valid = 1'b0; in_data = 8'h00;
    cfg_master = 1'b0; cfg_par_off = 1'b0; cfg_sum_off = 1'b0;
    cfg_classic = 1'b0; cfg_len_from_id = 1'b0; cfg_len_code = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!out_valid && !in_ready, "R12", "reset handshake", {out_valid, in_ready}, 0);
    chk(!par_err && !sum_err && !frame_done, "R11", "reset flags", {par_err, sum_err, frame_done}, 0);
    @(posedge clk);
    #1;
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    mon_en = 1'b1;

    // Master, length boundaries, both checksum types
    run_frame(1, 0, 0, 0, 0, 8'd0, 8'h3A, 0, 0);
    rdy_rand = 1'b1;
    run_frame(1, 0, 0, 1, 0, 8'd255, 8'h15, 0, 0);
    // Identifier-driven length, all four codes, code ignored
    run_frame(1, 0, 0, 0, 1, 8'd200, 8'h05, 0, 0);
    run_frame(1, 0, 0, 1, 1, 8'd200, 8'h1C, 0, 0);
    run_frame(1, 0, 0, 0, 1, 8'd200, 8'h2B, 0, 0);
    run_frame(1, 0, 0, 0, 1, 8'd200, 8'h3E, 0, 0);
    // Parity and checksum switched off in master role
    run_frame(1, 1, 0, 0, 0, 8'd3, 8'hC5, 0, 0);
    run_frame(1, 0, 1, 0, 0, 8'd4, 8'h22, 0, 0);
    // Slave good frames
    run_frame(0, 0, 0, 0, 0, 8'd7, 8'h31, 0, 0);
    run_frame(0, 0, 0, 1, 1, 8'd0, 8'h29, 0, 0);
    // Slave bad parity: sticky, then cleared by frame start
    run_frame(0, 0, 0, 0, 0, 8'd2, 8'h11, 1, 0);
    repeat (3) @(negedge clk);
    chk(par_err == 1'b1, "R3", "par_err sticky", int'(par_err), 1);
    start_frame(0, 0, 0, 0, 0, 8'd0);
    @(negedge clk);
    chk(!par_err && !sum_err, "R11", "flags cleared by start", {par_err, sum_err}, 0);
    // Slave bad checksum
    run_frame(0, 0, 0, 0, 0, 8'd5, 8'h0F, 0, 1);
    chk(sum_err == 1'b1, "R9", "sum_err after bad checksum", int'(sum_err), 1);
    // Disabled checks ignore corruption
    run_frame(0, 1, 0, 1, 0, 8'd1, 8'h07, 1, 0);
    run_frame(0, 0, 1, 0, 0, 8'd6, 8'h12, 0, 1);
    // Mid-frame restart
    start_frame(1, 0, 0, 0, 0, 8'd9);
    push({m_par(6'h24), 6'h24}, "R11");
    send(8'h24);
    push(8'hA5, "R11");
    send(8'hA5);
    run_frame(1, 0, 0, 0, 0, 8'd2, 8'h19, 0, 0);
    // Random mix
    for (int k = 0; k < 40; k++) begin
      logic [7:0] code;
      code = 8'($urandom % 24);
      run_frame($urandom % 2, ($urandom % 4) == 0, ($urandom % 4) == 0, $urandom % 2,
                $urandom % 2, code, 8'($urandom), ($urandom % 3) == 0, ($urandom % 3) == 0);
    end
  endtask

  initial begin
    fork
      main_seq();
      begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "R12", "watchdog expired", 0, 1);
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule